// File: doc/BRIEF.md
# Clocked Read Port for a Two-Phase Toggle FIFO

This block is the consumer end of a self-timed FIFO whose cells talk with two-phase toggle handshakes. The final cell of the FIFO raises a request by inverting its request wire and puts a data word next to it. That wire may change at any moment relative to the local read clock. The port brings the request into the read clock domain and signals that a word is waiting. When the reader enables a read, the port inverts its acknowledge wire back toward the cell, which frees the cell for the next word.

"Ready" means only that the synchronized request and the local acknowledge differ. The acknowledge is a toggle register whose clock enable is ready AND read-enable. The data word is taken into a read-clock register on the same edge on which the request change comes out of the synchronizer. The request follows its data, so the word is already steady when it is taken.

Top module: `toggle_rd_port`

## Requirements
- R1: While reset is high, and on the first edge after it, the acknowledge output is 0, ready is 0 and the read data is 0.
- R2: Ready is high exactly when the synchronized request differs from the acknowledge. After the request input inverts, ready rises on the second rising clock edge, counting the first edge that samples the new level.
- R3: When ready rises, the read data equals the word that was present on the data input while the request inverted. The read data stays unchanged for as long as ready stays high.
- R4: On a rising edge where ready and read-enable are both high, the acknowledge output inverts. It changes on no other edge.
- R5: While read-enable is low, a waiting word stays in place: ready stays high, the acknowledge holds and the read data holds.
- R6: After a transfer edge, ready is low in the next cycle unless a newer request change has already come through the synchronizer.
- R7: Read-enable held high while ready is low has no effect: the acknowledge and the read data stay unchanged.
- R8: A stream of words sent by a cell that obeys the handshake is read in order. No word is read twice and none is skipped, whether read-enable is held high or stalls at times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_tgl_i | input | 1 | Request toggle from the final FIFO cell, asynchronous to clk_i |
| req_data_i | input | DATA_W | Data word from the final FIFO cell, steady before the request changes |
| rd_en_i | input | 1 | Read enable from the reader |
| rd_rdy_o | output | 1 | A word is waiting (handshake toggles differ) |
| rd_data_o | output | DATA_W | Registered read data |
| ack_tgl_o | output | 1 | Acknowledge toggle back to the final FIFO cell |

## Verification
A request change applied at a falling edge is sampled by the next rising edge. Ready and the read data are then due one rising edge later, so the bench checks that ready is still low at the falling edge after the first rising edge and high, with the new word, at the falling edge after the second. An acknowledge caused by a transfer is due at the transfer edge itself, and ready must read low at the falling edge that follows. Every check samples at a falling edge and compares against the expected value for that cycle, never against "eventually". The stream scenarios keep their own expected sequence, so a repeated or missing word is caught at the cycle where it would be read.

// File: rtl/toggle_rd_pkg.sv
package toggle_rd_pkg;

    parameter int unsigned TRP_DATA_W      = 8;
    parameter int unsigned TRP_SYNC_STAGES = 2;

    // handshake state as seen in the read clock domain
    typedef struct packed {
        logic req_seen;   // synchronized request toggle
        logic ack;        // local acknowledge toggle
    } trp_hs_t;

    // a word is waiting when the two toggles disagree
    function automatic logic trp_pending(input trp_hs_t hs);
        return hs.req_seen ^ hs.ack;
    endfunction

    // a transfer fires when a word waits and the reader enables
    function automatic logic trp_fire(input trp_hs_t hs, input logic en);
        return trp_pending(hs) & en;
    endfunction

endpackage

// File: rtl/trp_sync.sv
module trp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o,
    output logic q_prev_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[0] <= 1'b0;
                    else       chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[s] <= 1'b0;
                    else       chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o      = chain_q[LAST];
    assign q_prev_o = chain_q[LAST-1];
endmodule

// File: rtl/trp_capture.sv
module trp_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              take_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)       word_q <= '0;
        else if (take_i) word_q <= d_i;
    end

    assign q_o = word_q;
endmodule

// File: rtl/trp_ack_ctl.sv
module trp_ack_ctl
    import toggle_rd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_seen_i,
    input  logic rd_en_i,
    output logic rdy_o,
    output logic ack_o
);
    logic    ack_q;
    trp_hs_t hs;

    always_comb begin
        hs.req_seen = req_seen_i;
        hs.ack      = ack_q;
    end

    // acknowledge toggles only when the clock enable (ready AND enable) is set
    always_ff @(posedge clk_i) begin
        if (rst_i)                    ack_q <= 1'b0;
        else if (trp_fire(hs, rd_en_i)) ack_q <= ~ack_q;
    end

    assign rdy_o = trp_pending(hs);
    assign ack_o = ack_q;
endmodule

// File: rtl/toggle_rd_port.sv
module toggle_rd_port
    import toggle_rd_pkg::*;
#(
    parameter int unsigned DATA_W      = TRP_DATA_W,
    parameter int unsigned SYNC_STAGES = TRP_SYNC_STAGES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_tgl_i,
    input  logic [DATA_W-1:0] req_data_i,
    input  logic              rd_en_i,
    output logic              rd_rdy_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ack_tgl_o
);
    localparam int unsigned STAGES_USED = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic req_seen;
    logic req_pend;
    logic req_edge;

    trp_sync #(.STAGES(STAGES_USED)) u_sync (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .d_i      (req_tgl_i),
        .q_o      (req_seen),
        .q_prev_o (req_pend)
    );

    // the request change leaves the synchronizer on this edge
    assign req_edge = req_pend ^ req_seen;

    trp_capture #(.DATA_W(DATA_W)) u_cap (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .take_i (req_edge),
        .d_i    (req_data_i),
        .q_o    (rd_data_o)
    );

    trp_ack_ctl u_ack (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .req_seen_i (req_seen),
        .rd_en_i    (rd_en_i),
        .rdy_o      (rd_rdy_o),
        .ack_o      (ack_tgl_o)
    );
endmodule

// File: rtl/toggle_rd_checker.sv
module toggle_rd_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              rd_rdy,
    input logic              ack,
    input logic [DATA_W-1:0] rd_data,
    input logic              req_seen,
    input logic              req_pend
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!ack && !rd_rdy && rd_data == '0));

    p_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_rdy) |-> $past(req_pend != req_seen));

    p_hold_data_r3: assert property (@(posedge clk) disable iff (rst)
        rd_rdy |=> $stable(rd_data));

    p_ack_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_rdy && rd_en) |=> (ack != $past(ack)));

    p_ack_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(rd_rdy && rd_en) |=> $stable(ack));

    p_drop_after_read_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_rdy && rd_en && (req_pend == req_seen)) |=> !rd_rdy);

    p_idle_enable_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_rdy && (req_pend == req_seen)) |=> ($stable(rd_data) && $stable(ack)));
endmodule

bind toggle_rd_port toggle_rd_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .rd_en    (rd_en_i),
    .rd_rdy   (rd_rdy_o),
    .ack      (ack_tgl_o),
    .rd_data  (rd_data_o),
    .req_seen (req_seen),
    .req_pend (req_pend)
);

// File: tb/toggle_rd_port_bench.sv
`timescale 1ns/1ps
module toggle_rd_port_bench;
    localparam int unsigned DW = 8;
    localparam int unsigned N_STREAM = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_tgl = 1'b0;
    logic [DW-1:0] req_data = '0;
    logic          rd_en = 1'b0;
    logic          rd_rdy;
    logic [DW-1:0] rd_data;
    logic          ack_tgl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    toggle_rd_port #(.DATA_W(DW), .SYNC_STAGES(2)) u_toggle_rd_port (
        .clk_i      (clk),
        .rst_i      (rst),
        .req_tgl_i  (req_tgl),
        .req_data_i (req_data),
        .rd_en_i    (rd_en),
        .rd_rdy_o   (rd_rdy),
        .rd_data_o  (rd_data),
        .ack_tgl_o  (ack_tgl)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(ack_tgl == 1'b0, "R1 ack in reset", ack_tgl, 0);
        chk(rd_rdy == 1'b0, "R1 ready in reset", rd_rdy, 0);
        chk(rd_data == '0, "R1 data in reset", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_rdy == 1'b0 && ack_tgl == 1'b0, "R1 state after release", {rd_rdy, ack_tgl}, 0);
    endtask

    // one word: latency, hold with no enable, then the transfer
    task automatic t_single();
        logic ack0;
        ack0 = ack_tgl;
        req_data = 8'hA5;
        @(negedge clk);
        req_tgl = ~req_tgl;
        @(negedge clk);
        chk(rd_rdy == 1'b0, "R2 ready one edge after toggle", rd_rdy, 0);
        @(negedge clk);
        chk(rd_rdy == 1'b1, "R2 ready two edges after toggle", rd_rdy, 1);
        chk(rd_data == 8'hA5, "R3 data at ready rise", rd_data, 8'hA5);
        req_data = 8'h3C; // cell data may move once taken; must not leak
        repeat (3) @(negedge clk);
        chk(rd_rdy == 1'b1, "R5 ready held without enable", rd_rdy, 1);
        chk(ack_tgl == ack0, "R5 ack held without enable", ack_tgl, ack0);
        chk(rd_data == 8'hA5, "R5 data held without enable", rd_data, 8'hA5);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(ack_tgl == ~ack0, "R4 ack inverts on transfer", ack_tgl, ~ack0);
        chk(rd_rdy == 1'b0, "R6 ready low after transfer", rd_rdy, 0);
    endtask

    task automatic t_enable_idle();
        logic ack0;
        logic [DW-1:0] d0;
        ack0 = ack_tgl;
        d0 = rd_data;
        rd_en = 1'b1;
        req_data = 8'hEE;
        repeat (4) @(negedge clk);
        chk(ack_tgl == ack0, "R7 ack unchanged when idle", ack_tgl, ack0);
        chk(rd_rdy == 1'b0, "R7 ready stays low when idle", rd_rdy, 0);
        chk(rd_data == d0, "R7 data unchanged when idle", rd_data, d0);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    // stream from a handshake-obeying cell; stall_mod==0 means enable always high
    task automatic t_stream(input int stall_mod, input logic [DW-1:0] base);
        fork
            begin : producer
                for (int i = 0; i < N_STREAM; i++) begin
                    @(negedge clk);
                    while (ack_tgl != req_tgl) @(negedge clk);
                    req_data = base + DW'(i);
                    @(negedge clk);
                    req_tgl = ~req_tgl;
                end
            end
            begin : consumer
                int got = 0;
                int cyc = 0;
                bit took_prev = 1'b0;
                while (got < N_STREAM) begin
                    @(negedge clk);
                    cyc++;
                    if (took_prev)
                        chk(rd_rdy == 1'b0, "R6 no second read of a word", rd_rdy, 0);
                    rd_en = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
                    took_prev = 1'b0;
                    if (rd_rdy && rd_en) begin
                        chk(rd_data == base + DW'(got), "R8 order, no skip/dup",
                            rd_data, base + DW'(got));
                        got++;
                        took_prev = 1'b1;
                    end
                end
                @(negedge clk);
                rd_en = 1'b0;
                chk(rd_rdy == 1'b0, "R8 nothing extra after stream", rd_rdy, 0);
            end
        join
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_enable_idle();
        t_stream(0, 8'h10);
        t_stream(3, 8'h80);
        t_single();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule